// File: doc/BRIEF.md
# Repeat-Loop and Breakpoint Next-PC Sequencer

This block owns the program counter of a small processor and decides, once per retired instruction, where fetch goes next. A retire strobe marks the end of one instruction. If that instruction wrote the PC itself (a branch or jump), the supplied target wins. Otherwise the block either steps one word forward or, when a zero-overhead hardware repeat loop is running and the PC sits on the loop's last address, counts one pass off the loop and jumps back to the loop head. When the last pass is counted, the loop shuts itself off and execution falls through.

A single instruction-address breakpoint is checked against the PC of the instruction being retired. On a hit, the block still works out the ordinary next PC, stores it together with the current status word, hands out a reduced status word that keeps only the supervisor-mode bit, and sends the PC to a fixed debug vector. Loop registers are loaded through a setup write that may arrive in any cycle, including the cycle of a retire.

Top module: `pc_step_seq`

## Requirements
- R1: While `rst` is high (sampled at a rising edge), the PC becomes 0xFFC0, the loop count becomes 0, the loop is inactive, the saved PC, saved status and reduced status become 0 and `trap_o` is 0.
- R2: On a retire with `pc_wr_i` low, no loop-end hit and no breakpoint hit, the PC becomes the old PC plus one, wrapping from 0xFFFF to 0x0000.
- R3: On a retire with `pc_wr_i` low, the loop active and the PC equal to the loop end address, the loop count drops by one; if the new count is not zero, the PC becomes the loop start address and the loop stays active.
- R4: When that decrement brings the count to zero, the loop becomes inactive and the PC becomes the old PC plus one.
- R5: On a retire with `pc_wr_i` high, the PC becomes `pc_tgt_i` and the loop count and active flag are unchanged, even when the PC equals the loop end address.
- R6: A setup write (`lp_set_i` high) loads loop start, end and count, and sets the loop active exactly when the loaded count is not zero; it takes precedence over a decrement in the same cycle, while the next PC of a retire in that cycle is still chosen from the loop values held before the write.
- R7: A breakpoint hit needs `dbg_en_i` high and the PC of the retiring instruction equal to `brk_addr_i`; without a hit the PC follows R2 to R5 and `trap_o` stays 0.
- R8: On a breakpoint hit, the PC becomes the debug vector 0x3FF0, the saved PC gets the next PC that R2 to R5 would have chosen, the saved status gets `psw_i`, the reduced status gets `psw_i` with every bit except bit 15 (the supervisor-mode bit) cleared, and `trap_o` is 1 for that one cycle; loop count updates of R3/R4 still take place.
- R9: In a cycle with neither a retire nor a setup write, PC, loop count and loop active flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retires this cycle |
| pc_wr_i | input | 1 | The retiring instruction wrote the PC |
| pc_tgt_i | input | 16 | PC value written by the instruction |
| lp_set_i | input | 1 | Loop setup write |
| lp_start_i | input | 16 | Loop start word address to load |
| lp_end_i | input | 16 | Loop last word address to load |
| lp_cnt_i | input | 16 | Loop pass count to load |
| dbg_en_i | input | 1 | Debug breakpoints enabled |
| brk_addr_i | input | 16 | Breakpoint word address |
| psw_i | input | 16 | Current status word |
| pc_o | output | 16 | Program counter |
| lp_cnt_o | output | 16 | Remaining loop passes |
| lp_act_o | output | 1 | Repeat loop active |
| brk_pc_o | output | 16 | PC saved on the last breakpoint |
| brk_psw_o | output | 16 | Status word saved on the last breakpoint |
| psw_new_o | output | 16 | Reduced status word issued on the last breakpoint |
| trap_o | output | 1 | Breakpoint taken on the previous edge |

## Verification
Two pairs of functions can land on the same clock edge. A loop-end decrement can coincide with a breakpoint hit: the bench sets the breakpoint on the loop's last address and expects the PC at the vector, the saved PC equal to the loop start and the count one lower. A setup write can coincide with a retire at loop end: the bench expects the count from the setup data while the PC still returns to the old loop start, and separately checks that a branch on the loop end is taken with the count untouched.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    NXT_INC  = 2'd0,
    NXT_TGT  = 2'd1,
    NXT_LOOP = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/pcs_loop_ctl.sv
module pcs_loop_ctl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_i,
  input  logic          pc_wr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          set_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] start_o,
  output logic [CW-1:0] cnt_o,
  output logic          act_o,
  output logic          at_end_o,
  output logic          last_o
);
  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] cnt_q, cnt_dec;
  logic          act_q;

  always_comb begin
    cnt_dec  = cnt_q - 1'b1;
    at_end_o = act_q && !pc_wr_i && (pc_i == end_q);
    last_o   = at_end_o && (cnt_dec == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else if (set_i) begin
      start_q <= start_i;
      end_q   <= end_i;
      cnt_q   <= cnt_i;
      act_q   <= (cnt_i != '0);
    end else if (retire_i && at_end_o) begin
      cnt_q <= cnt_dec;
      if (last_o) act_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (retire_i && at_end_o && !set_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_loop_off_R4: assert property (@(posedge clk) disable iff (rst)
    (retire_i && last_o && !set_i) |=> !act_q);

  assert_setup_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (cnt_q == $past(cnt_i)) && (act_q == ($past(cnt_i) != '0)));
endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc_i,
  input  logic          pc_wr_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          at_end_i,
  input  logic          last_i,
  input  logic [AW-1:0] start_i,
  output nxt_sel_e      sel_o,
  output logic [AW-1:0] nxt_o
);
  always_comb begin
    if (pc_wr_i)                 sel_o = NXT_TGT;
    else if (at_end_i && !last_i) sel_o = NXT_LOOP;
    else                         sel_o = NXT_INC;
    unique case (sel_o)
      NXT_TGT:  nxt_o = tgt_i;
      NXT_LOOP: nxt_o = start_i;
      default:  nxt_o = pc_i + 1'b1;
    endcase
  end
endmodule

// File: rtl/pcs_brk_trap.sv
module pcs_brk_trap #(
  parameter int AW     = 16,
  parameter int SW     = 16,
  parameter int SM_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_i,
  input  logic          dbg_en_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] brk_addr_i,
  input  logic [AW-1:0] nxt_i,
  input  logic [SW-1:0] psw_i,
  output logic          hit_o,
  output logic [AW-1:0] brk_pc_o,
  output logic [SW-1:0] brk_psw_o,
  output logic [SW-1:0] psw_new_o,
  output logic          trap_o
);
  localparam logic [SW-1:0] SM_MASK = SW'(1) << SM_BIT;

  assign hit_o = dbg_en_i && (pc_i == brk_addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_pc_o  <= '0;
      brk_psw_o <= '0;
      psw_new_o <= '0;
      trap_o    <= 1'b0;
    end else begin
      trap_o <= retire_i && hit_o;
      if (retire_i && hit_o) begin
        brk_pc_o  <= nxt_i;
        brk_psw_o <= psw_i;
        psw_new_o <= psw_i & SM_MASK;
      end
    end
  end

  assert_no_trap_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !dbg_en_i) |=> !trap_o);

  assert_status_saved_R8: assert property (@(posedge clk) disable iff (rst)
    (retire_i && hit_o) |=> trap_o && (brk_psw_o == $past(psw_i)) &&
                            ((psw_new_o & ~SM_MASK) == '0));
endmodule

// File: rtl/pc_step_seq.sv
module pc_step_seq #(
  parameter int                AW       = 16,
  parameter int                CW       = 16,
  parameter int                SW       = 16,
  parameter int                SM_BIT   = 15,
  parameter logic [AW-1:0]     RESET_PC = 16'hFFC0,
  parameter logic [AW-1:0]     DBG_VEC  = 16'h3FF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_i,
  input  logic          pc_wr_i,
  input  logic [AW-1:0] pc_tgt_i,
  input  logic          lp_set_i,
  input  logic [AW-1:0] lp_start_i,
  input  logic [AW-1:0] lp_end_i,
  input  logic [CW-1:0] lp_cnt_i,
  input  logic          dbg_en_i,
  input  logic [AW-1:0] brk_addr_i,
  input  logic [SW-1:0] psw_i,
  output logic [AW-1:0] pc_o,
  output logic [CW-1:0] lp_cnt_o,
  output logic          lp_act_o,
  output logic [AW-1:0] brk_pc_o,
  output logic [SW-1:0] brk_psw_o,
  output logic [SW-1:0] psw_new_o,
  output logic          trap_o
);
  import pcs_pkg::*;

  logic [AW-1:0] pc_q, nxt, lp_start;
  logic          at_end, last, hit;
  nxt_sel_e      sel;

  pcs_loop_ctl #(.AW(AW), .CW(CW)) u_loop (
    .clk(clk), .rst(rst), .retire_i(retire_i), .pc_wr_i(pc_wr_i), .pc_i(pc_q),
    .set_i(lp_set_i), .start_i(lp_start_i), .end_i(lp_end_i), .cnt_i(lp_cnt_i),
    .start_o(lp_start), .cnt_o(lp_cnt_o), .act_o(lp_act_o),
    .at_end_o(at_end), .last_o(last)
  );

  pcs_next_pc #(.AW(AW)) u_nxt (
    .pc_i(pc_q), .pc_wr_i(pc_wr_i), .tgt_i(pc_tgt_i), .at_end_i(at_end),
    .last_i(last), .start_i(lp_start), .sel_o(sel), .nxt_o(nxt)
  );

  pcs_brk_trap #(.AW(AW), .SW(SW), .SM_BIT(SM_BIT)) u_brk (
    .clk(clk), .rst(rst), .retire_i(retire_i), .dbg_en_i(dbg_en_i), .pc_i(pc_q),
    .brk_addr_i(brk_addr_i), .nxt_i(nxt), .psw_i(psw_i), .hit_o(hit),
    .brk_pc_o(brk_pc_o), .brk_psw_o(brk_psw_o), .psw_new_o(psw_new_o),
    .trap_o(trap_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_PC;
    else if (retire_i) pc_q <= hit ? DBG_VEC : nxt;
  end

  assign pc_o = pc_q;

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !pc_wr_i && !at_end && !hit) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_branch_R5: assert property (@(posedge clk) disable iff (rst)
    (retire_i && pc_wr_i && !hit && !lp_set_i) |=>
      (pc_q == $past(pc_tgt_i)) && $stable(lp_cnt_o) && $stable(lp_act_o));

  assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
    (retire_i && hit) |=> (pc_q == DBG_VEC) && (brk_pc_o == $past(nxt)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!retire_i && !lp_set_i) |=> $stable(pc_q) && $stable(lp_cnt_o) && $stable(lp_act_o));
endmodule

// File: tb/pc_step_seq_test.sv
module pc_step_seq_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        retire_i = 0, pc_wr_i = 0, lp_set_i = 0, dbg_en_i = 0;
  logic [15:0] pc_tgt_i = 0, lp_start_i = 0, lp_end_i = 0, lp_cnt_i = 0;
  logic [15:0] brk_addr_i = 0, psw_i = 0;
  logic [15:0] pc_o, lp_cnt_o, brk_pc_o, brk_psw_o, psw_new_o;
  logic        lp_act_o, trap_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_step_seq uut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .pc_wr_i(pc_wr_i), .pc_tgt_i(pc_tgt_i),
    .lp_set_i(lp_set_i), .lp_start_i(lp_start_i), .lp_end_i(lp_end_i), .lp_cnt_i(lp_cnt_i),
    .dbg_en_i(dbg_en_i), .brk_addr_i(brk_addr_i), .psw_i(psw_i), .pc_o(pc_o),
    .lp_cnt_o(lp_cnt_o), .lp_act_o(lp_act_o), .brk_pc_o(brk_pc_o), .brk_psw_o(brk_psw_o),
    .psw_new_o(psw_new_o), .trap_o(trap_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one cycle, driven and finished at negedge
  task automatic cyc(input logic ret, input logic w, input logic [15:0] t,
                     input logic set, input logic [15:0] s, input logic [15:0] e,
                     input logic [15:0] c);
    retire_i = ret; pc_wr_i = w; pc_tgt_i = t;
    lp_set_i = set; lp_start_i = s; lp_end_i = e; lp_cnt_i = c;
    @(negedge clk);
    retire_i = 0; pc_wr_i = 0; lp_set_i = 0;
  endtask

  task automatic step();                         cyc(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic jump(input logic [15:0] t);     cyc(1, 1, t, 0, 0, 0, 0); endtask
  task automatic setup(input logic [15:0] s, input logic [15:0] e, input logic [15:0] c);
    cyc(0, 0, 0, 1, s, e, c);
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_o, 16'hFFC0);
    chk("R1 cnt", lp_cnt_o, 0);
    chk("R1 act", {15'd0, lp_act_o}, 0);
    chk("R1 brk_pc", brk_pc_o, 0);
    chk("R1 brk_psw", brk_psw_o, 0);
    chk("R1 psw_new", psw_new_o, 0);
    chk("R1 trap", {15'd0, trap_o}, 0);
  endtask

  task automatic t_seq();
    repeat (3) step();
    chk("R2 increment", pc_o, 16'hFFC3);
    jump(16'hFFFF);
    chk("R5 jump", pc_o, 16'hFFFF);
    step();
    chk("R2 wrap", pc_o, 16'h0000);
  endtask

  task automatic t_loop();
    jump(16'h0010);
    setup(16'h0010, 16'h0012, 16'd3);
    chk("R9 pc held on setup", pc_o, 16'h0010);
    chk("R6 act set", {15'd0, lp_act_o}, 1);
    step(); step(); step();
    chk("R3 back to start", pc_o, 16'h0010);
    chk("R3 count 2", lp_cnt_o, 16'd2);
    step(); step(); step();
    chk("R3 count 1", lp_cnt_o, 16'd1);
    step(); step(); step();
    chk("R4 fall through", pc_o, 16'h0013);
    chk("R4 count 0", lp_cnt_o, 16'd0);
    chk("R4 inactive", {15'd0, lp_act_o}, 0);
    step();
    chk("R2 after loop", pc_o, 16'h0014);
  endtask

  task automatic t_branch_end();
    jump(16'h0020);
    setup(16'h0020, 16'h0021, 16'd2);
    step();
    jump(16'h0040);
    chk("R5 branch at end", pc_o, 16'h0040);
    chk("R5 count kept", lp_cnt_o, 16'd2);
    chk("R5 act kept", {15'd0, lp_act_o}, 1);
  endtask

  task automatic t_override();
    jump(16'h0030);
    setup(16'h0030, 16'h0031, 16'd4);
    step();
    cyc(1, 0, 0, 1, 16'h0050, 16'h0052, 16'd5);
    chk("R6 old start used", pc_o, 16'h0030);
    chk("R6 setup count wins", lp_cnt_o, 16'd5);
    setup(16'h0050, 16'h0052, 16'd0);
    chk("R6 zero count inactive", {15'd0, lp_act_o}, 0);
  endtask

  task automatic t_idle();
    repeat (4) @(negedge clk);
    chk("R9 pc idle", pc_o, 16'h0030);
    chk("R9 cnt idle", lp_cnt_o, 16'd0);
  endtask

  task automatic t_brk();
    jump(16'h0100);
    dbg_en_i = 1; brk_addr_i = 16'h0100; psw_i = 16'hFFFF;
    step();
    chk("R8 vector", pc_o, 16'h3FF0);
    chk("R8 saved pc", brk_pc_o, 16'h0101);
    chk("R8 saved psw", brk_psw_o, 16'hFFFF);
    chk("R8 reduced psw", psw_new_o, 16'h8000);
    chk("R8 trap", {15'd0, trap_o}, 1);
    @(negedge clk);
    chk("R8 trap one cycle", {15'd0, trap_o}, 0);
    jump(16'h0200);
    dbg_en_i = 0; brk_addr_i = 16'h0200;
    step();
    chk("R7 disabled pc", pc_o, 16'h0201);
    chk("R7 disabled trap", {15'd0, trap_o}, 0);
    chk("R7 saved pc kept", brk_pc_o, 16'h0101);
    dbg_en_i = 1; brk_addr_i = 16'h0999;
    step();
    chk("R7 mismatch pc", pc_o, 16'h0202);
    chk("R7 mismatch trap", {15'd0, trap_o}, 0);
  endtask

  task automatic t_brk_loop();
    dbg_en_i = 0;
    jump(16'h0060);
    setup(16'h0060, 16'h0061, 16'd2);
    dbg_en_i = 1; brk_addr_i = 16'h0061; psw_i = 16'h1234;
    step();
    step();
    chk("R8 loop vector", pc_o, 16'h3FF0);
    chk("R8 saved loop start", brk_pc_o, 16'h0060);
    chk("R3 count with trap", lp_cnt_o, 16'd1);
    chk("R8 psw no sm", psw_new_o, 16'h0000);
    chk("R8 psw saved", brk_psw_o, 16'h1234);
    brk_addr_i = 16'h3FF0;
    jump(16'h0777);
    chk("R8 saved target", brk_pc_o, 16'h0777);
    chk("R8 branch vector", pc_o, 16'h3FF0);
    dbg_en_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_seq();
    t_loop();
    t_branch_end();
    t_override();
    t_idle();
    t_brk();
    t_brk_loop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule